// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is an SPI slave that fronts a 512-byte memory array. A host drives chip select (active low), the serial clock and serial data in; the block decodes an 8-bit command, gathers a byte address, and then streams data out or takes data in. The serial pins are oversampled by the block's own system clock, so all internal state lives in one clock domain and the serial clock may run at any rate well below it, or stop at either level in the middle of a byte.

Array writes go through a 16-byte page buffer. They are gated by a write enable latch and committed only when chip select rises on a byte boundary. A fixed-length busy window models the nonvolatile programming time, and the write enable latch and busy flag are brought out as pins as well as through the status byte.

Top module: `spi_mem_slave`

## Requirements
- R1: SI is taken on SCK rising edges starting with the first rise after CS goes low, SO changes after SCK falling edges, and every byte travels most significant bit first.
- R2: Command 0x06 sets the write enable latch and command 0x04 clears it. Each is a one-byte command, and wel_o reflects the latch.
- R3: Command 0x05 returns the status byte {user[5:0], latch, busy}, with busy in bit 0 and the latch in bit 1. The byte repeats for as long as CS stays low.
- R4: Command 0x01 followed by one byte loads status bits 7:2 from that byte when CS rises on a byte boundary. This happens only if the latch is set and the block is not busy, and it then clears the latch and starts a busy window. Without the latch the command has no effect.
- R5: Read command 0000_A011 (bit 3 = address bit 8), followed by the low address byte, streams bytes from the 9-bit address upward. The address wraps from 511 to 0.
- R6: Write command 0000_A010 (bit 3 = address bit 8), followed by the low address byte and 1 to 16 data bytes, stores those bytes once CS rises on a byte boundary.
- R7: During a write the byte address wraps within its 16-byte page, and a later byte for the same location replaces an earlier one.
- R8: If CS rises while a write data byte is incomplete, the whole write is discarded, memory is unchanged and the latch stays set.
- R9: A write or status write issued while the latch is clear leaves memory and status unchanged.
- R10: busy_o is high for BUSY_CYCLES clock cycles after each commit. A write command issued while busy is refused, and the latch stays set.
- R11: The latch clears when a write commits.
- R12: CS high resets the bit counter and command decoder, and so_oe_o is low while CS is high. Pausing SCK mid-byte does not corrupt a transfer.
- R13: After reset the latch and busy flag are clear, the status user bits are 0, SO is disabled and every memory byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o; the pad is high impedance when low |
| wel_o | output | 1 | Write enable latch state |
| busy_o | output | 1 | Programming in progress |

## Verification
The assertions check these rules on every cycle: a commit is never issued while busy, the latch is already clear when a commit fires, the latch stays set for the whole of a write data phase, the decoder and bit counter return to idle after CS rises, and the busy counter loads on a commit and then counts down one step per cycle. What the assertions cannot show is whether the right bytes end up in the right places. Only the bench scenarios show the data itself: MSB-first streaming, wrap at the 9-bit and 16-byte boundaries, discarding a partial-byte write, refusing writes without the latch or while busy, the status byte contents, and how long the busy window lasts as seen from the pins.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int ADDR_W     = 9;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 16;
  localparam int PAGE_W     = $clog2(PAGE_BYTES);
  localparam int BASE_W     = ADDR_W - PAGE_W;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_A8_CLR = 8'hF7;

  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRD, ST_SWR, ST_SKIP
  } seq_state_e;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic cs_act_o,
  output logic cs_rise_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic si_o
);
  logic [2:0] cs_q, sck_q;
  logic [1:0] si_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 3'b111;
      sck_q <= 3'b000;
      si_q  <= 2'b00;
    end else begin
      cs_q  <= {cs_q[1:0], cs_ni};
      sck_q <= {sck_q[1:0], sck_i};
      si_q  <= {si_q[0], si_i};
    end
  end

  assign cs_act_o   = ~cs_q[1];
  assign cs_rise_o  = cs_q[1] & ~cs_q[2];
  assign sck_rise_o = sck_q[1] & ~sck_q[2];
  assign sck_fall_o = ~sck_q[1] & sck_q[2];
  assign si_o       = si_q[1];
endmodule

// File: rtl/spi_mem_seq.sv
module spi_mem_seq
  import spi_mem_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_act_i,
  input  logic                    cs_rise_i,
  input  logic                    sck_rise_i,
  input  logic                    sck_fall_i,
  input  logic                    si_i,
  input  logic                    busy_i,
  input  logic [7:0]              rd_data_i,
  output logic [ADDR_W-1:0]       rd_addr_o,
  output logic                    commit_o,
  output logic [BASE_W-1:0]       cm_base_o,
  output logic [PAGE_BYTES*8-1:0] cm_data_o,
  output logic [PAGE_BYTES-1:0]   cm_mask_o,
  output logic                    wel_o,
  output logic                    so_o,
  output logic                    so_oe_o
);
  seq_state_e           state;
  logic [2:0]           bit_cnt;
  logic [6:0]           sh;
  logic                 a8, is_wr;
  logic [ADDR_W-1:0]    rd_ptr;
  logic [7:0]           tx;
  logic                 so_q, wel_q, commit_q;
  logic [5:0]           user_q, swr_user;
  logic                 swr_got;
  logic [7:0]           pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [PAGE_W-1:0]    poff;
  logic [BASE_W-1:0]    pbase;

  logic [7:0]        byte_in;
  logic [ADDR_W-1:0] addr_in;
  logic [7:0]        status;

  assign byte_in = {sh, si_i};
  assign addr_in = {a8, byte_in};
  assign status  = {user_q, wel_q, busy_i};
  // address phase reads ahead so the first byte is ready at the next fall
  assign rd_addr_o = (state == ST_ADDR) ? addr_in : rd_ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_OP;
      bit_cnt  <= '0;
      sh       <= '0;
      a8       <= 1'b0;
      is_wr    <= 1'b0;
      rd_ptr   <= '0;
      tx       <= '0;
      so_q     <= 1'b0;
      wel_q    <= 1'b0;
      commit_q <= 1'b0;
      user_q   <= '0;
      swr_user <= '0;
      swr_got  <= 1'b0;
      pmask    <= '0;
      poff     <= '0;
      pbase    <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else begin
      commit_q <= 1'b0;
      if (cs_rise_i) begin
        state   <= ST_OP;
        bit_cnt <= '0;
        if (state == ST_WDATA && bit_cnt == 3'd0 && |pmask) begin
          commit_q <= 1'b1;
          wel_q    <= 1'b0;
        end
        if (state == ST_SWR && bit_cnt == 3'd0 && swr_got) begin
          commit_q <= 1'b1;
          wel_q    <= 1'b0;
          user_q   <= swr_user;
        end
      end else if (cs_act_i && sck_rise_i) begin
        sh      <= byte_in[6:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == 3'd7) begin
          unique case (state)
            ST_OP: begin
              pmask <= '0;
              if (byte_in == OP_WREN) begin
                wel_q <= 1'b1;
                state <= ST_SKIP;
              end else if (byte_in == OP_WRDI) begin
                wel_q <= 1'b0;
                state <= ST_SKIP;
              end else if (byte_in == OP_RDSR) begin
                tx    <= status;
                state <= ST_SRD;
              end else if (byte_in == OP_WRSR) begin
                swr_got <= 1'b0;
                state   <= (wel_q && !busy_i) ? ST_SWR : ST_SKIP;
              end else if ((byte_in & OP_A8_CLR) == OP_READ) begin
                a8    <= byte_in[3];
                is_wr <= 1'b0;
                state <= ST_ADDR;
              end else if ((byte_in & OP_A8_CLR) == OP_WRITE) begin
                a8    <= byte_in[3];
                is_wr <= 1'b1;
                state <= (wel_q && !busy_i) ? ST_ADDR : ST_SKIP;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_ADDR: begin
              if (is_wr) begin
                pbase <= addr_in[ADDR_W-1:PAGE_W];
                poff  <= addr_in[PAGE_W-1:0];
                state <= ST_WDATA;
              end else begin
                tx     <= rd_data_i;
                rd_ptr <= addr_in + 1'b1;
                state  <= ST_RDATA;
              end
            end
            ST_RDATA: begin
              tx     <= rd_data_i;
              rd_ptr <= rd_ptr + 1'b1;
            end
            ST_SRD: tx <= status;
            ST_WDATA: begin
              pbuf[poff]  <= byte_in;
              pmask[poff] <= 1'b1;
              poff        <= poff + 1'b1;
            end
            ST_SWR: begin
              if (!swr_got) begin
                swr_user <= byte_in[7:2];
                swr_got  <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end else if (cs_act_i && sck_fall_i) begin
        if (state == ST_RDATA || state == ST_SRD) begin
          so_q <= tx[7];
          tx   <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    assign cm_data_o[g*8 +: 8] = pbuf[g];
  end

  assign commit_o  = commit_q;
  assign cm_base_o = pbase;
  assign cm_mask_o = pmask;
  assign wel_o     = wel_q;
  assign so_o      = so_q;
  assign so_oe_o   = cs_act_i && (state == ST_RDATA || state == ST_SRD);

  p_commit_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !busy_i);
  p_wel_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !wel_q);
  p_wr_needs_wel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WDATA || state == ST_SWR) |-> wel_q);
  p_cs_reset_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> (state == ST_OP && bit_cnt == 3'd0));
endmodule

// File: rtl/spi_mem_store.sv
module spi_mem_store
  import spi_mem_pkg::*;
#(
  parameter int BUSY_CYCLES = 1024
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    commit_i,
  input  logic [BASE_W-1:0]       base_i,
  input  logic [PAGE_BYTES*8-1:0] data_i,
  input  logic [PAGE_BYTES-1:0]   mask_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [7:0]              rd_data_o,
  output logic                    busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (mask_i[i]) mem[{base_i, i[PAGE_W-1:0]}] <= data_i[i*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt <= '0;
    else if (commit_i)      cnt <= CNT_W'(BUSY_CYCLES);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign rd_data_o = mem[rd_addr_i];
  assign busy_o    = (cnt != '0);

  p_busy_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> busy_o);
  p_busy_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int BUSY_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic so_o,
  output logic so_oe_o,
  output logic wel_o,
  output logic busy_o
);
  logic cs_act, cs_rise, sck_rise, sck_fall, si_s;
  logic commit;
  logic [BASE_W-1:0]       cm_base;
  logic [PAGE_BYTES*8-1:0] cm_data;
  logic [PAGE_BYTES-1:0]   cm_mask;
  logic [ADDR_W-1:0]       rd_addr;
  logic [7:0]              rd_data;

  spi_mem_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sck_i      (sck_i),
    .si_i       (si_i),
    .cs_act_o   (cs_act),
    .cs_rise_o  (cs_rise),
    .sck_rise_o (sck_rise),
    .sck_fall_o (sck_fall),
    .si_o       (si_s)
  );

  spi_mem_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .cs_rise_i  (cs_rise),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .si_i       (si_s),
    .busy_i     (busy_o),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .commit_o   (commit),
    .cm_base_o  (cm_base),
    .cm_data_o  (cm_data),
    .cm_mask_o  (cm_mask),
    .wel_o      (wel_o),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o)
  );

  spi_mem_store #(.BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (commit),
    .base_i    (cm_base),
    .data_i    (cm_data),
    .mask_i    (cm_mask),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .busy_o    (busy_o)
  );
endmodule

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;
  localparam int BUSY = 1024;
  localparam int H    = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe, wel, busy;
  int checks = 0, fails = 0;
  logic [7:0] exp_mem [512];
  logic [5:0] exp_user = '0;

  always #2 clk = ~clk;

  spi_mem_slave #(.BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .wel_o(wel), .busy_o(busy)
  );

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    ticks(H);
  endtask

  task automatic cs_end();
    ticks(H);
    cs_n = 1'b1;
    ticks(2 * H);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input bit pause);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      ticks(H);
      rx[i] = so;
      sck = 1'b1;
      ticks((pause && i == 4) ? 12 * H : H);
      sck = 1'b0;
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    cs_begin();
    xfer(op, r, 0);
    cs_end();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    cs_begin();
    xfer(8'h05, r, 0);
    xfer(8'h00, s, 0);
    cs_end();
  endtask

  task automatic wait_idle();
    int g;
    g = 0;
    while (busy === 1'b1 && g < 5000) begin
      ticks(1);
      g++;
    end
    ticks(2);
  endtask

  task automatic read_chk(input logic [8:0] a, input int n, input string req, input bit pause);
    logic [7:0] r;
    logic [8:0] p;
    cs_begin();
    xfer({4'b0000, a[8], 3'b011}, r, 0);
    xfer(a[7:0], r, 0);
    for (int k = 0; k < n; k++) begin
      p = a + 9'(k);
      xfer(8'h00, r, pause && k == 0);
      chk(req, r, exp_mem[p]);
    end
    cs_end();
  endtask

  task automatic write_txn(input logic [8:0] a, input int n, input logic [7:0] base_val);
    logic [7:0] r;
    logic [3:0] off;
    cs_begin();
    xfer({4'b0000, a[8], 3'b010}, r, 0);
    xfer(a[7:0], r, 0);
    for (int k = 0; k < n; k++) begin
      xfer(base_val + 8'(k), r, 0);
      off = a[3:0] + 4'(k);
      exp_mem[{a[8:4], off}] = base_val + 8'(k);
    end
  endtask

  // R13
  task automatic t_reset();
    logic [7:0] s;
    chk("R13 wel", wel, 0);
    chk("R13 busy", busy, 0);
    chk("R13 so_oe", so_oe, 0);
    rdsr(s);
    chk("R13 status", s, 8'h00);
    read_chk(9'h000, 2, "R13 mem zero", 0);
  endtask

  // R2 R3
  task automatic t_wel();
    logic [7:0] r, s0, s1;
    cmd(8'h06);
    chk("R2 wren", wel, 1);
    cs_begin();
    xfer(8'h05, r, 0);
    xfer(8'h00, s0, 0);
    xfer(8'h00, s1, 0);
    cs_end();
    chk("R3 status first", s0, 8'h02);
    chk("R3 status repeat", s1, 8'h02);
    cmd(8'h04);
    chk("R2 wrdi", wel, 0);
    rdsr(s0);
    chk("R3 status after wrdi", s0, 8'h00);
  endtask

  // R1 R6 R11
  task automatic t_write();
    cmd(8'h06);
    write_txn(9'h010, 3, 8'h11);
    cs_end();
    chk("R11 wel cleared", wel, 0);
    wait_idle();
    read_chk(9'h010, 3, "R1 R6 data", 0);
  endtask

  // R5
  task automatic t_wrap();
    cmd(8'h06);
    write_txn(9'h1FE, 2, 8'hA0);
    cs_end();
    wait_idle();
    cmd(8'h06);
    write_txn(9'h000, 1, 8'h5C);
    cs_end();
    wait_idle();
    read_chk(9'h1FE, 3, "R5 high addr and wrap", 0);
  endtask

  // R7
  task automatic t_page();
    cmd(8'h06);
    write_txn(9'h02C, 18, 8'h40);
    cs_end();
    wait_idle();
    read_chk(9'h020, 16, "R7 page wrap", 0);
  endtask

  // R8
  task automatic t_partial();
    logic [7:0] r;
    cmd(8'h06);
    cs_begin();
    xfer(8'h02, r, 0);
    xfer(8'h30, r, 0);
    xfer(8'h99, r, 0);
    for (int i = 0; i < 3; i++) begin
      si = 1'b1;
      ticks(H);
      sck = 1'b1;
      ticks(H);
      sck = 1'b0;
    end
    cs_end();
    chk("R8 wel kept", wel, 1);
    chk("R8 no busy", busy, 0);
    read_chk(9'h030, 2, "R8 memory unchanged", 0);
    cmd(8'h04);
  endtask

  // R9
  task automatic t_nowel();
    logic [7:0] r, s;
    cs_begin();
    xfer(8'h02, r, 0);
    xfer(8'h50, r, 0);
    xfer(8'h77, r, 0);
    cs_end();
    chk("R9 no busy", busy, 0);
    read_chk(9'h050, 1, "R9 memory unchanged", 0);
    cs_begin();
    xfer(8'h01, r, 0);
    xfer(8'hFC, r, 0);
    cs_end();
    rdsr(s);
    chk("R9 status unchanged", s, {exp_user, 2'b00});
  endtask

  // R10
  task automatic t_busy();
    logic [7:0] r, s;
    int n;
    cmd(8'h06);
    write_txn(9'h060, 1, 8'h3C);
    cs_end();
    chk("R10 busy after commit", busy, 1);
    rdsr(s);
    chk("R10 status busy bit", s, {exp_user, 2'b01});
    cmd(8'h06);
    cs_begin();
    xfer(8'h02, r, 0);
    xfer(8'h61, r, 0);
    xfer(8'hEE, r, 0);
    cs_end();
    chk("R10 wel kept on refusal", wel, 1);
    wait_idle();
    read_chk(9'h060, 2, "R10 refused write", 0);
    write_txn(9'h070, 1, 8'h81);
    ticks(H);
    cs_n = 1'b1;
    n = 0;
    ticks(1);
    n++;
    while (busy !== 1'b1 && n < 20) begin
      ticks(1);
      n++;
    end
    while (busy === 1'b1 && n < BUSY + 100) begin
      ticks(1);
      n++;
    end
    if (n >= BUSY + 1 && n <= BUSY + 8) chk("R10 busy length", 1, 1);
    else chk("R10 busy length", n, BUSY + 4);
    ticks(2 * H);
    read_chk(9'h070, 1, "R10 post-busy data", 0);
  endtask

  // R4
  task automatic t_wrsr();
    logic [7:0] r, s;
    cmd(8'h06);
    cs_begin();
    xfer(8'h01, r, 0);
    xfer(8'hA9, r, 0);
    cs_end();
    exp_user = 6'b101010;
    chk("R4 wel cleared", wel, 0);
    rdsr(s);
    chk("R4 status while busy", s, 8'hA9);
    wait_idle();
    rdsr(s);
    chk("R4 status settled", s, 8'hA8);
  endtask

  // R12 R1
  task automatic t_cs();
    logic [7:0] r, s;
    chk("R12 oe idle", so_oe, 0);
    cs_begin();
    xfer(8'h03, r, 0);
    xfer(8'h10, r, 0);
    chk("R12 oe in read", so_oe, 1);
    ticks(H);
    cs_n = 1'b1;
    ticks(H);
    chk("R12 oe after cs high", so_oe, 0);
    ticks(H);
    cs_begin();
    for (int i = 0; i < 5; i++) begin
      si = 1'b1;
      ticks(H);
      sck = 1'b1;
      ticks(H);
      sck = 1'b0;
    end
    cs_end();
    rdsr(s);
    chk("R12 decoder reset", s, {exp_user, 2'b00});
    read_chk(9'h011, 2, "R12 R1 paused clock", 1);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'h00;
    ticks(5);
    rst_n = 1'b1;
    ticks(5);
    t_reset();
    t_wel();
    t_write();
    t_wrap();
    t_page();
    t_partial();
    t_nowel();
    t_busy();
    t_wrsr();
    t_cs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule